// File: doc/BRIEF.md
# Serial Port Receive Queue and Interrupt Registers

This block is the register-side half of a serial port. A host reaches it through a simple word-addressed register port with separate read and write strobes. Bytes that the (external) line receiver has assembled arrive on a byte-valid input and are stored in a receive queue. The queue holds 16 bytes when the line-control register enables it, and only a single byte otherwise. A byte written to the data register leaves at once on a one-cycle byte-valid output.

Status flags report queue empty and full. Two raw interrupt sources, receive and transmit, are gated by a mask register to form the masked status and the single interrupt line. The receive source fires when the queue reaches a programmable trigger level and drops when a read takes the level one below it. The transmit source fires on every data write. Both are cleared through a write-one-to-clear register. Baud-rate and control registers are storage only, and eight identification words sit at the top of the register window.

Top module: `uart_rxq_regs`

## Requirements
- R1: After reset the status word at word offset 6 reads 0x90 (bit 7 transmit empty and bit 4 receive empty set), the raw status reads 0, the mask reads 0, and irq_o is low.
- R2: With line-control bit 4 set (word offset 11), the receive queue holds up to 16 bytes and returns them in arrival order. With bit 4 clear it accepts a single byte.
- R3: A byte that arrives while the queue already holds its capacity is dropped. Flags, raw status and queue contents are left unchanged.
- R4: Status bit 4 (receive empty) clears on every accepted byte. Status bit 6 (receive full) sets on an accepted byte when the queue is disabled or the level reaches 16. Status bit 7 reads 1 and bit 5 reads 0.
- R5: A read of word offset 0 returns the oldest byte, clears receive full, and removes one byte if any is held. When the level reaches zero, receive empty sets.
- R6: Raw receive bit 4 (word offset 15) sets when an accepted byte makes the level equal to the trigger. It clears when a data read makes the level equal to the trigger minus one.
- R7: With the queue enabled, the trigger is bits [5:2] of (level register at word offset 13, shifted right by one), or 1 if that value is zero. With the queue disabled, the trigger is 1.
- R8: A write to word offset 0 pulses tx_valid_o on the next cycle with tx_byte_o equal to the low data byte, and sets raw transmit bit 5.
- R9: The mask at word offset 14 keeps bits 5 and 4. Word offset 16 reads the raw status ANDed with the mask, and irq_o is high exactly when that value is nonzero.
- R10: A write to word offset 17 clears each raw bit (5, 4) that is written as one.
- R11: Word offsets 1016 to 1023 read 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05 and 0xB1.
- R12: The registers at word offsets 8 (8 bits), 9 (16 bits), 10 (6 bits) and 12 (16 bits) read back what was written. Writing them changes no flag, interrupt or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 10 | Word offset of the register access |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Register read strobe; a read of offset 0 consumes a byte |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| rx_valid_i | input | 1 | Received byte valid |
| rx_byte_i | input | 8 | Received byte |
| tx_valid_o | output | 1 | Transmit byte valid, one cycle per data write |
| tx_byte_o | output | 8 | Transmit byte |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The assertions on queue level and flags assume that a byte arrival and a data-register read do not share a cycle. Where that case matters, they condition on its absence. They also assume that read and write strobes are never raised together. The stimulus drives each register access and each arriving byte in a cycle of its own, with an idle cycle between operations. It never raises more than one of the read strobe, the write strobe and the byte-valid input at a time. Transmit bytes are checked by a queue of expected values that drains as tx_valid_o pulses. Any pulse without a pending expectation counts as an error.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int ADDR_W  = 10;
  localparam int LVL_W   = 6;

  localparam logic [ADDR_W-1:0] OFF_DATA   = 10'd0;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 10'd6;
  localparam logic [ADDR_W-1:0] OFF_LPWR   = 10'd8;
  localparam logic [ADDR_W-1:0] OFF_DIVI   = 10'd9;
  localparam logic [ADDR_W-1:0] OFF_DIVF   = 10'd10;
  localparam logic [ADDR_W-1:0] OFF_LINE   = 10'd11;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 10'd12;
  localparam logic [ADDR_W-1:0] OFF_LEVEL  = 10'd13;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 10'd14;
  localparam logic [ADDR_W-1:0] OFF_RAW    = 10'd15;
  localparam logic [ADDR_W-1:0] OFF_MST    = 10'd16;
  localparam logic [ADDR_W-1:0] OFF_ICLR   = 10'd17;

  localparam int LINE_QEN_BIT = 4;

  // raw interrupt vector index (2 bits), mapped to bits 5/4 on the bus
  localparam int IRQ_RX = 0;
  localparam int IRQ_TX = 1;
  localparam int IRQ_LSB = 4;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h11;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  function automatic logic [LVL_W-1:0] trig_level(input logic qen, input logic [LVL_W-1:0] lvl);
    logic [LVL_W-1:0] t;
    t = {1'b0, lvl[LVL_W-1:1]} & 6'h1C;
    if (!qen || t == '0) trig_level = 6'd1;
    else trig_level = t;
  endfunction
endpackage

// File: rtl/uart_rxq_fifo.sv
module uart_rxq_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              qen_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic              accept_o,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  mid_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr;
  logic [PTR_W-1:0]  wr_idx;
  logic [CNT_W-1:0]  cap;
  logic              pop_hit;

  assign pop_hit  = pop_i && (count_o != '0);
  assign mid_o    = count_o - CNT_W'(pop_hit);
  assign cap      = qen_i ? CNT_W'(DEPTH) : CNT_W'(1);
  assign accept_o = push_i && (mid_o < cap);
  // tail slot: pointer arithmetic wraps, DEPTH is a power of two
  assign wr_idx   = rd_ptr + PTR_W'(count_o);
  assign head_o   = mem[rd_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (accept_o) begin
      for (int i = 0; i < DEPTH; i++)
        if (wr_idx == PTR_W'(i)) mem[i] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (pop_hit) rd_ptr <= rd_ptr + PTR_W'(1);
      count_o <= mid_o + CNT_W'(accept_o);
    end
  end
endmodule

// File: rtl/uart_rxq_irq.sv
module uart_rxq_irq #(
  parameter int NSRC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rx_set_i,
  input  logic            rx_clr_i,
  input  logic            tx_set_i,
  input  logic            clr_we_i,
  input  logic [NSRC-1:0] clr_val_i,
  input  logic [NSRC-1:0] mask_i,
  output logic [NSRC-1:0] raw_o,
  output logic [NSRC-1:0] masked_o,
  output logic            irq_o
);
  import uart_rxq_pkg::*;
  logic [NSRC-1:0] raw_n;

  always_comb begin
    raw_n = raw_o;
    if (clr_we_i) raw_n = raw_n & ~clr_val_i;
    if (rx_clr_i) raw_n[IRQ_RX] = 1'b0;
    if (rx_set_i) raw_n[IRQ_RX] = 1'b1;
    if (tx_set_i) raw_n[IRQ_TX] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_o <= '0;
    else raw_o <= raw_n;
  end

  assign masked_o = raw_o & mask_i;
  assign irq_o    = |masked_o;
endmodule

// File: rtl/uart_rxq_regs.sv
module uart_rxq_regs #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int AW    = uart_rxq_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  input  logic              rd_en_i,
  output logic [31:0]       rdata_o,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic              irq_o
);
  import uart_rxq_pkg::*;
  localparam int NSRC = 2;

  logic [7:0]       lpwr_q;
  logic [15:0]      divi_q;
  logic [5:0]       divf_q;
  logic [7:0]       line_q;
  logic [15:0]      ctrl_q;
  logic [LVL_W-1:0] level_q;
  logic [NSRC-1:0]  mask_q;
  logic             rxff_q, rxfe_q;

  logic              fifo_en, pop, accept, rx_hit;
  logic [DATA_W-1:0] head;
  logic [CNT_W-1:0]  fill_cnt, cnt_mid;
  logic [LVL_W-1:0]  trig;
  logic [NSRC-1:0]   ris_q, mis;
  logic              wr_data, wr_clr;
  logic [15:0]       unused_wdata;

  assign unused_wdata = wdata_i[31:16];
  assign fifo_en = line_q[LINE_QEN_BIT];
  assign pop     = rd_en_i && (addr_i == OFF_DATA);
  assign wr_data = wr_en_i && (addr_i == OFF_DATA);
  assign wr_clr  = wr_en_i && (addr_i == OFF_ICLR);
  assign trig    = trig_level(fifo_en, level_q);
  assign rx_hit  = (int'(cnt_mid) + 1 == int'(trig));

  uart_rxq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .qen_i    (fifo_en),
    .push_i   (rx_valid_i),
    .data_i   (rx_byte_i),
    .pop_i    (pop),
    .accept_o (accept),
    .head_o   (head),
    .count_o  (fill_cnt),
    .mid_o    (cnt_mid)
  );

  uart_rxq_irq #(.NSRC(NSRC)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_set_i  (accept && rx_hit),
    .rx_clr_i  (pop && rx_hit),
    .tx_set_i  (wr_data),
    .clr_we_i  (wr_clr),
    .clr_val_i (wdata_i[IRQ_LSB +: NSRC]),
    .mask_i    (mask_q),
    .raw_o     (ris_q),
    .masked_o  (mis),
    .irq_o     (irq_o)
  );

  // receive flags: read clears full first, an arrival may set it again
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxff_q <= 1'b0;
      rxfe_q <= 1'b1;
    end else begin
      if (pop) rxff_q <= 1'b0;
      if (accept) begin
        rxfe_q <= 1'b0;
        if (!fifo_en || int'(cnt_mid) + 1 == DEPTH) rxff_q <= 1'b1;
      end else if (pop && cnt_mid == '0) begin
        rxfe_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lpwr_q  <= '0;
      divi_q  <= '0;
      divf_q  <= '0;
      line_q  <= '0;
      ctrl_q  <= '0;
      level_q <= '0;
      mask_q  <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        OFF_LPWR:  lpwr_q  <= wdata_i[7:0];
        OFF_DIVI:  divi_q  <= wdata_i[15:0];
        OFF_DIVF:  divf_q  <= wdata_i[5:0];
        OFF_LINE:  line_q  <= wdata_i[7:0];
        OFF_CTRL:  ctrl_q  <= wdata_i[15:0];
        OFF_LEVEL: level_q <= wdata_i[LVL_W-1:0];
        OFF_MASK:  mask_q  <= wdata_i[IRQ_LSB +: NSRC];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_byte_o  <= '0;
    end else begin
      tx_valid_o <= wr_data;
      if (wr_data) tx_byte_o <= wdata_i[DATA_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i[AW-1:3] == '1) begin
      rdata_o[7:0] = id_byte(addr_i[2:0]);
    end else begin
      case (addr_i)
        OFF_DATA:  rdata_o[DATA_W-1:0] = head;
        OFF_STAT:  rdata_o[7:4] = {1'b1, rxff_q, 1'b0, rxfe_q};
        OFF_LPWR:  rdata_o[7:0] = lpwr_q;
        OFF_DIVI:  rdata_o[15:0] = divi_q;
        OFF_DIVF:  rdata_o[5:0] = divf_q;
        OFF_LINE:  rdata_o[7:0] = line_q;
        OFF_CTRL:  rdata_o[15:0] = ctrl_q;
        OFF_LEVEL: rdata_o[LVL_W-1:0] = level_q;
        OFF_MASK:  rdata_o[IRQ_LSB +: NSRC] = mask_q;
        OFF_RAW:   rdata_o[IRQ_LSB +: NSRC] = ris_q;
        OFF_MST:   rdata_o[IRQ_LSB +: NSRC] = mis;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [9:0]       addr_i,
  input logic             wr_en_i,
  input logic [31:0]      wdata_i,
  input logic             rd_en_i,
  input logic             rx_valid_i,
  input logic             tx_valid_o,
  input logic [7:0]       tx_byte_o,
  input logic [CNT_W-1:0] fill_cnt,
  input logic             fifo_en,
  input logic             rxfe_q,
  input logic [1:0]       ris_q
);
  logic [CNT_W-1:0] cap;
  logic             rd_data;
  assign cap     = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
  assign rd_data = rd_en_i && (addr_i == 10'd0);

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_cnt <= CNT_W'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rd_data && fill_cnt >= cap) |=> $stable(fill_cnt));

  assert_empty_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rd_data && fill_cnt < cap) |=> !rxfe_q);

  assert_pop_one_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && fill_cnt != '0 && !rx_valid_i) |=> (fill_cnt + CNT_W'(1) == $past(fill_cnt)));

  assert_tx_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 10'd0) |=> (tx_valid_o && tx_byte_o == $past(wdata_i[7:0])));

  assert_clear_all_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 10'd17 && wdata_i[5:4] == 2'b11 && !rx_valid_i) |=> (ris_q == 2'b00));
endmodule

bind uart_rxq_regs uart_rxq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_en_i    (wr_en_i),
  .wdata_i    (wdata_i),
  .rd_en_i    (rd_en_i),
  .rx_valid_i (rx_valid_i),
  .tx_valid_o (tx_valid_o),
  .tx_byte_o  (tx_byte_o),
  .fill_cnt   (fill_cnt),
  .fifo_en    (fifo_en),
  .rxfe_q     (rxfe_q),
  .ris_q      (ris_q)
);

// File: tb/uart_rxq_regs_tb.sv
module uart_rxq_regs_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_tx[$];

  always #4 clk = ~clk;

  uart_rxq_regs u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rd_en_i(rd_en), .rdata_o(rdata), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .tx_valid_o(tx_valid), .tx_byte_o(tx_byte), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); addr = 10'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); addr = 10'(a); rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic rx(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    exp_tx.push_back(b);
    wr(0, {24'h0, b});
  endtask

  // scoreboard monitor for transmit bytes (R8)
  always @(negedge clk) begin
    if (rst_ni && tx_valid) begin
      if (exp_tx.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8: unexpected tx byte 0x%0h expected none", tx_byte);
      end else begin
        chk("R8 tx byte", {24'h0, tx_byte}, {24'h0, exp_tx.pop_front()});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] ids [8];
    ids = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd_chk("R1 status", 6, 32'h90);
    rd_chk("R1 raw", 15, 32'h0);
    rd_chk("R1 mask", 14, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R11 identification words
    for (int i = 0; i < 8; i++) rd_chk("R11 id", 1016 + i, {24'h0, ids[i]});

    // single-byte mode; level register ignored (R7 trigger 1)
    wr(13, 32'h08);
    rx(8'hA5);
    rd_chk("R4 full+nonempty single mode", 6, 32'hC0);
    rd_chk("R6 R7 rx irq at trigger 1", 15, 32'h10);
    rx(8'h3C);
    rd_chk("R3 drop keeps flags", 6, 32'hC0);
    rd_chk("R3 drop keeps raw", 15, 32'h10);
    wr(14, 32'h10);
    rd_chk("R9 masked", 16, 32'h10);
    chk("R9 irq high", {31'h0, irq}, 32'h1);
    wr(17, 32'h10);
    rd_chk("R10 clear rx", 15, 32'h0);
    chk("R10 irq low", {31'h0, irq}, 32'h0);
    rd_chk("R5 R3 oldest byte kept", 0, 32'hA5);
    rd_chk("R5 empty after read", 6, 32'h90);
    wr(14, 32'h0);

    // 16-deep mode, trigger (8>>1)&0x1C = 4
    wr(11, 32'h10);
    for (int i = 0; i < 3; i++) rx(8'(8'h40 + i));
    rd_chk("R6 below trigger", 15, 32'h0);
    rx(8'h43);
    rd_chk("R6 R7 at trigger 4", 15, 32'h10);
    rd_chk("R4 partial", 6, 32'h80);
    for (int i = 4; i < 16; i++) rx(8'(8'h40 + i));
    rd_chk("R2 R4 full at 16", 6, 32'hC0);
    rx(8'h99);
    rd_chk("R3 drop when 16 held", 6, 32'hC0);
    for (int i = 0; i < 16; i++) begin
      rd_chk("R2 R5 order", 0, {24'h0, 8'(8'h40 + i)});
      if (i == 0) rd_chk("R5 full cleared", 6, 32'h80);
      if (i == 11) rd_chk("R6 held at level 4", 15, 32'h10);
      if (i == 12) rd_chk("R6 cleared at level 3", 15, 32'h0);
    end
    rd_chk("R5 empty again", 6, 32'h90);
    rd_chk("R5 read when empty keeps flags", 6, 32'h90);

    // R7 zero field forces trigger 1
    wr(13, 32'h0);
    rx(8'h77);
    rd_chk("R7 forced trigger 1", 15, 32'h10);
    rd_chk("R5 R6 read byte", 0, 32'h77);
    rd_chk("R6 cleared at 0", 15, 32'h0);

    // R8 transmit
    send(8'h5A);
    send(8'hC3);
    rd_chk("R8 tx raw", 15, 32'h20);
    wr(14, 32'h20);
    chk("R9 tx irq", {31'h0, irq}, 32'h1);
    wr(17, 32'h20);
    chk("R10 tx cleared", {31'h0, irq}, 32'h0);
    wr(14, 32'h0);

    // R12 storage-only registers
    wr(9, 32'h1234);  rd_chk("R12 int divisor", 9, 32'h1234);
    wr(10, 32'h2A);   rd_chk("R12 frac divisor", 10, 32'h2A);
    wr(8, 32'h7F);    rd_chk("R12 low-power", 8, 32'h7F);
    wr(12, 32'h0301); rd_chk("R12 control", 12, 32'h0301);
    rd_chk("R12 no flag effect", 6, 32'h90);
    rd_chk("R12 no irq effect", 15, 32'h0);

    repeat (3) @(negedge clk);
    chk("R8 all tx seen", exp_tx.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule